// File: doc/BRIEF.md
# Per-Bank Row-Hit-First Request Scheduler

This block sits between a memory controller's request intake and its bank machines. It keeps pending requests in one age-ordered queue per bank. Each entry holds a row number, a read/write flag and a tag. Every cycle, each bank receives one registered candidate. The choice depends on the state that bank's machine reports. When the bank is open, the candidate is the oldest entry whose row matches the open row. When the bank is closed, or when no entry matches, the candidate is the oldest entry in that bank's queue.

The page policy uses two lookahead hints. The first says that a bank still holds more than one request. The second says that a queried bank and row would see another row hit. A bank machine that has served a request drops it by tag. The entry can sit anywhere in the queue, and the younger entries close the gap in order. A strict-FIFO mode turns the block into a plain in-order queue per bank. In that mode removal pops the head and the row-hit hint only looks at the second entry. An external admission controller decides whether intake has space.

Top module: `rowhit_req_sched`

## Requirements
- R1: An accepted request for bank `enq_bank_i` is appended behind every older entry of that bank's queue, so each queue stays in arrival order.
- R2: In row-hit-first mode (`fifo_mode_i` = 0), when a bank is open (`bank_open_i[b]` = 1), the candidate is the oldest queued entry whose row equals that bank's `open_row_i` field.
- R3: When a bank is closed, or no entry matches the open row, the candidate is the oldest entry of that bank.
- R4: A bank whose queue is empty presents `gnt_valid_o[b]` = 0.
- R5: A removal for bank `rm_bank_i` in row-hit-first mode deletes the oldest entry carrying `rm_tag_i`, shifts the younger entries forward in order, and changes nothing if no entry carries that tag.
- R6: `more_req_o[b]` is 1 exactly when bank b holds two or more entries.
- R7: In row-hit-first mode, `more_hit_o` is 1 when the queue of bank `hint_bank_i` holds at least two entries whose row equals `hint_row_i`.
- R8: In strict-FIFO mode, the candidate is always the head, a removal pops the head whatever its tag, and `more_hit_o` is 1 only when the second entry's row equals `hint_row_i`.
- R9: An enqueue and a removal in the same cycle both take effect. The removal applies first, so a full queue can accept the new entry in that cycle.
- R10: An enqueue is dropped when `space_ok_i` is 0, or when the target queue is still full after any same-cycle removal. No queue ever holds more than DEPTH entries.
- R11: Candidates are registered. The grant outputs after a clock edge reflect the queue contents and bank inputs present before that edge. Reset empties all queues and clears all grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects strict-FIFO mode |
| space_ok_i | input | 1 | Admission controller allows intake |
| enq_valid_i | input | 1 | Enqueue request |
| enq_bank_i | input | BANK_W | Target bank of the enqueue |
| enq_row_i | input | ROW_W | Row of the new request |
| enq_wr_i | input | 1 | 1 = write, 0 = read |
| enq_tag_i | input | TAG_W | Tag of the new request |
| rm_valid_i | input | 1 | Removal request |
| rm_bank_i | input | BANK_W | Bank of the removal |
| rm_tag_i | input | TAG_W | Tag to remove |
| bank_open_i | input | NUM_BANKS | Per-bank activated flag |
| open_row_i | input | NUM_BANKS*ROW_W | Per-bank open row, bank b at bits b*ROW_W |
| hint_bank_i | input | BANK_W | Bank queried for the row-hit hint |
| hint_row_i | input | ROW_W | Row queried for the row-hit hint |
| gnt_valid_o | output | NUM_BANKS | Per-bank candidate present |
| gnt_row_o | output | NUM_BANKS*ROW_W | Per-bank candidate row |
| gnt_wr_o | output | NUM_BANKS | Per-bank candidate write flag |
| gnt_tag_o | output | NUM_BANKS*TAG_W | Per-bank candidate tag |
| more_req_o | output | NUM_BANKS | Per-bank two-or-more-entries hint |
| more_hit_o | output | 1 | Further row hit hint for the queried bank and row |

## Verification
The hardest case to reach is a removal from the middle of a full queue in the same cycle as an enqueue to that bank. If the shift and the append are ordered wrongly, the result is a lost or duplicated entry. A second hard case is a removal by a tag that appears twice. The bench reaches both on purpose. It fills bank 0 with repeated tags and rows, then issues a combined remove-and-enqueue. A long random phase follows that draws rows and tags from small pools, so matches and duplicates are common. A behavioural queue model is compared against every output on every cycle.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  // Reason a bank's candidate was chosen
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HEAD = 2'd1,
    SRC_HIT  = 2'd2
  } pick_src_e;
endpackage

// File: rtl/rhs_bank_queue.sv
module rhs_bank_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int TAG_W = 4,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fifo_mode_i,
  input  logic                        enq_i,
  input  logic [ROW_W-1:0]            enq_row_i,
  input  logic                        enq_wr_i,
  input  logic [TAG_W-1:0]            enq_tag_i,
  input  logic                        rm_i,
  input  logic [TAG_W-1:0]            rm_tag_i,
  output logic [DEPTH-1:0][ROW_W-1:0] row_o,
  output logic [DEPTH-1:0]            wr_o,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_o,
  output logic [CNT_W-1:0]            cnt_o
);
  logic [DEPTH-1:0][ROW_W-1:0] row_q, row_d;
  logic [DEPTH-1:0]            wr_q, wr_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d, cnt_mid;
  logic                        rm_hit, enq_ok;
  logic [IDX_W-1:0]            rm_idx;

  // Locate entry to drop: head in FIFO mode, else oldest tag match
  always_comb begin
    rm_hit = 1'b0;
    rm_idx = '0;
    if (rm_i && cnt_q != '0) begin
      if (fifo_mode_i) begin
        rm_hit = 1'b1;
      end else begin
        for (int i = DEPTH - 1; i >= 0; i--) begin
          if (i < int'(cnt_q) && tag_q[i] == rm_tag_i) begin
            rm_hit = 1'b1;
            rm_idx = IDX_W'(i);
          end
        end
      end
    end
  end

  assign cnt_mid = cnt_q - CNT_W'(rm_hit);
  assign enq_ok  = enq_i && (cnt_mid < CNT_W'(DEPTH));
  assign cnt_d   = cnt_mid + CNT_W'(enq_ok);

  // Removal closes the gap first, then the append lands at the new tail
  always_comb begin
    row_d = row_q;
    wr_d  = wr_q;
    tag_d = tag_q;
    if (rm_hit) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(rm_idx)) begin
          row_d[i] = row_q[i+1];
          wr_d[i]  = wr_q[i+1];
          tag_d[i] = tag_q[i+1];
        end
      end
      row_d[DEPTH-1] = '0;
      wr_d[DEPTH-1]  = 1'b0;
      tag_d[DEPTH-1] = '0;
    end
    if (enq_ok) begin
      row_d[cnt_mid[IDX_W-1:0]] = enq_row_i;
      wr_d[cnt_mid[IDX_W-1:0]]  = enq_wr_i;
      tag_d[cnt_mid[IDX_W-1:0]] = enq_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      wr_q  <= '0;
      tag_q <= '0;
      cnt_q <= '0;
    end else begin
      row_q <= row_d;
      wr_q  <= wr_d;
      tag_q <= tag_d;
      cnt_q <= cnt_d;
    end
  end

  assign row_o = row_q;
  assign wr_o  = wr_q;
  assign tag_o = tag_q;
  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R10
  AST_ENQ_AT_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_ok && !rm_hit |=> row_q[$past(cnt_q[IDX_W-1:0])] == $past(enq_row_i)); // R1
  AST_RM_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_hit && !enq_ok |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
  AST_ENQ_RM_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_hit && enq_ok |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/rhs_pick.sv
module rhs_pick
  import rhs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic                        fifo_mode_i,
  input  logic                        open_i,
  input  logic [ROW_W-1:0]            open_row_i,
  input  logic [ROW_W-1:0]            qry_row_i,
  output logic                        sel_vld_o,
  output logic [IDX_W-1:0]            sel_idx_o,
  output logic                        more_o,
  output logic                        hit2_o
);
  pick_src_e        src;
  logic             hit_found;
  logic [IDX_W-1:0] hit_idx;
  logic [CNT_W-1:0] n_match;

  always_comb begin
    hit_found = 1'b0;
    hit_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < int'(cnt_i) && row_i[i] == open_row_i) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (cnt_i == '0)                                src = SRC_NONE;
    else if (!fifo_mode_i && open_i && hit_found)   src = SRC_HIT;
    else                                            src = SRC_HEAD;
  end

  assign sel_vld_o = (src != SRC_NONE);
  assign sel_idx_o = (src == SRC_HIT) ? hit_idx : '0;
  assign more_o    = (cnt_i >= CNT_W'(2));

  always_comb begin
    n_match = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_i) && row_i[i] == qry_row_i) n_match = n_match + CNT_W'(1);
    end
  end

  assign hit2_o = fifo_mode_i ? (more_o && row_i[1] == qry_row_i)
                              : (n_match >= CNT_W'(2));
endmodule

// File: rtl/rowhit_req_sched.sv
module rowhit_req_sched #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fifo_mode_i,
  input  logic                         space_ok_i,
  input  logic                         enq_valid_i,
  input  logic [BANK_W-1:0]            enq_bank_i,
  input  logic [ROW_W-1:0]             enq_row_i,
  input  logic                         enq_wr_i,
  input  logic [TAG_W-1:0]             enq_tag_i,
  input  logic                         rm_valid_i,
  input  logic [BANK_W-1:0]            rm_bank_i,
  input  logic [TAG_W-1:0]             rm_tag_i,
  input  logic [NUM_BANKS-1:0]         bank_open_i,
  input  logic [NUM_BANKS*ROW_W-1:0]   open_row_i,
  input  logic [BANK_W-1:0]            hint_bank_i,
  input  logic [ROW_W-1:0]             hint_row_i,
  output logic [NUM_BANKS-1:0]         gnt_valid_o,
  output logic [NUM_BANKS*ROW_W-1:0]   gnt_row_o,
  output logic [NUM_BANKS-1:0]         gnt_wr_o,
  output logic [NUM_BANKS*TAG_W-1:0]   gnt_tag_o,
  output logic [NUM_BANKS-1:0]         more_req_o,
  output logic                         more_hit_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][ROW_W-1:0] q_row [NUM_BANKS];
  logic [DEPTH-1:0]            q_wr  [NUM_BANKS];
  logic [DEPTH-1:0][TAG_W-1:0] q_tag [NUM_BANKS];
  logic [CNT_W-1:0]            q_cnt [NUM_BANKS];
  logic [IDX_W-1:0]            sel_idx [NUM_BANKS];
  logic [NUM_BANKS-1:0]        sel_vld, hit2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic enq_b, rm_b;
    assign enq_b = enq_valid_i && space_ok_i && (enq_bank_i == BANK_W'(b));
    assign rm_b  = rm_valid_i && (rm_bank_i == BANK_W'(b));

    rhs_bank_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fifo_mode_i (fifo_mode_i),
      .enq_i       (enq_b),
      .enq_row_i   (enq_row_i),
      .enq_wr_i    (enq_wr_i),
      .enq_tag_i   (enq_tag_i),
      .rm_i        (rm_b),
      .rm_tag_i    (rm_tag_i),
      .row_o       (q_row[b]),
      .wr_o        (q_wr[b]),
      .tag_o       (q_tag[b]),
      .cnt_o       (q_cnt[b])
    );

    rhs_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_pick (
      .row_i       (q_row[b]),
      .cnt_i       (q_cnt[b]),
      .fifo_mode_i (fifo_mode_i),
      .open_i      (bank_open_i[b]),
      .open_row_i  (open_row_i[b*ROW_W +: ROW_W]),
      .qry_row_i   (hint_row_i),
      .sel_vld_o   (sel_vld[b]),
      .sel_idx_o   (sel_idx[b]),
      .more_o      (more_req_o[b]),
      .hit2_o      (hit2[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gnt_valid_o[b]                 <= 1'b0;
        gnt_row_o[b*ROW_W +: ROW_W]    <= '0;
        gnt_wr_o[b]                    <= 1'b0;
        gnt_tag_o[b*TAG_W +: TAG_W]    <= '0;
      end else begin
        gnt_valid_o[b]                 <= sel_vld[b];
        gnt_row_o[b*ROW_W +: ROW_W]    <= q_row[b][sel_idx[b]];
        gnt_wr_o[b]                    <= q_wr[b][sel_idx[b]];
        gnt_tag_o[b*TAG_W +: TAG_W]    <= q_tag[b][sel_idx[b]];
      end
    end

    AST_FIFO_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_mode_i && sel_vld[b] |-> sel_idx[b] == '0); // R8
    AST_HIT_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fifo_mode_i && bank_open_i[b] && sel_vld[b] && sel_idx[b] != '0
      |-> q_row[b][sel_idx[b]] == open_row_i[b*ROW_W +: ROW_W]); // R2
    AST_EMPTY_NOGNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt[b] == '0 |=> !gnt_valid_o[b]); // R4
  end

  assign more_hit_o = hit2[hint_bank_i];
endmodule

// File: tb/rowhit_req_sched_tb_top.sv
`timescale 1ns/1ps
module rowhit_req_sched_tb_top;
  localparam int NB = 4, DEPTH = 4, ROW_W = 8, TAG_W = 4, BW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, fifo_mode, space_ok, enq_valid, enq_wr, rm_valid;
  logic [BW-1:0] enq_bank, rm_bank, hint_bank;
  logic [ROW_W-1:0] enq_row, hint_row;
  logic [TAG_W-1:0] enq_tag, rm_tag;
  logic [NB-1:0] bank_open;
  logic [NB*ROW_W-1:0] open_row;
  logic [NB-1:0] gnt_valid, gnt_wr, more_req;
  logic [NB*ROW_W-1:0] gnt_row;
  logic [NB*TAG_W-1:0] gnt_tag;
  logic more_hit;

  rowhit_req_sched #(.NUM_BANKS(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_mode_i(fifo_mode), .space_ok_i(space_ok),
    .enq_valid_i(enq_valid), .enq_bank_i(enq_bank), .enq_row_i(enq_row),
    .enq_wr_i(enq_wr), .enq_tag_i(enq_tag), .rm_valid_i(rm_valid),
    .rm_bank_i(rm_bank), .rm_tag_i(rm_tag), .bank_open_i(bank_open),
    .open_row_i(open_row), .hint_bank_i(hint_bank), .hint_row_i(hint_row),
    .gnt_valid_o(gnt_valid), .gnt_row_o(gnt_row), .gnt_wr_o(gnt_wr),
    .gnt_tag_o(gnt_tag), .more_req_o(more_req), .more_hit_o(more_hit)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  string ph = "R11";

  // Behavioural reference queues
  int m_row [NB][DEPTH];
  int m_wr  [NB][DEPTH];
  int m_tag [NB][DEPTH];
  int m_cnt [NB];

  task automatic chk(bit ok, string what, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", ph, what, got, exp);
    end
  endtask

  task automatic m_drop(int b, int idx);
    for (int i = idx; i < m_cnt[b] - 1; i++) begin
      m_row[b][i] = m_row[b][i+1];
      m_wr[b][i]  = m_wr[b][i+1];
      m_tag[b][i] = m_tag[b][i+1];
    end
    m_cnt[b]--;
  endtask

  task automatic step();
    int e_v[NB], e_r[NB], e_w[NB], e_t[NB];
    #1;
    for (int b = 0; b < NB; b++)
      chk(more_req[b] == (m_cnt[b] >= 2), $sformatf("more_req bank%0d", b),
          int'(more_req[b]), int'(m_cnt[b] >= 2));
    begin
      int hb = int'(hint_bank), n = 0, eh;
      for (int i = 0; i < m_cnt[hb]; i++) if (m_row[hb][i] == int'(hint_row)) n++;
      if (fifo_mode) eh = int'(m_cnt[hb] >= 2 && m_row[hb][1] == int'(hint_row));
      else           eh = int'(n >= 2);
      chk(int'(more_hit) == eh, "more_hit", int'(more_hit), eh);
    end
    for (int b = 0; b < NB; b++) begin
      int idx = 0;
      if (!fifo_mode && bank_open[b]) begin
        for (int i = m_cnt[b] - 1; i >= 0; i--)
          if (m_row[b][i] == int'(open_row[b*ROW_W +: ROW_W])) idx = i;
      end
      e_v[b] = int'(m_cnt[b] > 0);
      e_r[b] = m_row[b][idx]; e_w[b] = m_wr[b][idx]; e_t[b] = m_tag[b][idx];
    end
    @(posedge clk);
    if (rm_valid) begin
      int b = int'(rm_bank), f = -1;
      if (m_cnt[b] > 0) begin
        if (fifo_mode) f = 0;
        else for (int i = m_cnt[b] - 1; i >= 0; i--) if (m_tag[b][i] == int'(rm_tag)) f = i;
      end
      if (f >= 0) m_drop(b, f);
    end
    if (enq_valid && space_ok && m_cnt[int'(enq_bank)] < DEPTH) begin
      int b = int'(enq_bank);
      m_row[b][m_cnt[b]] = int'(enq_row);
      m_wr[b][m_cnt[b]]  = int'(enq_wr);
      m_tag[b][m_cnt[b]] = int'(enq_tag);
      m_cnt[b]++;
    end
    #1;
    for (int b = 0; b < NB; b++) begin
      chk(int'(gnt_valid[b]) == e_v[b], $sformatf("gnt_valid bank%0d", b), int'(gnt_valid[b]), e_v[b]);
      if (e_v[b] != 0) begin
        chk(int'(gnt_row[b*ROW_W +: ROW_W]) == e_r[b], $sformatf("gnt_row bank%0d", b),
            int'(gnt_row[b*ROW_W +: ROW_W]), e_r[b]);
        chk(int'(gnt_wr[b]) == e_w[b], $sformatf("gnt_wr bank%0d", b), int'(gnt_wr[b]), e_w[b]);
        chk(int'(gnt_tag[b*TAG_W +: TAG_W]) == e_t[b], $sformatf("gnt_tag bank%0d", b),
            int'(gnt_tag[b*TAG_W +: TAG_W]), e_t[b]);
      end
    end
    @(negedge clk);
  endtask

  task automatic enq(int b, int row, int wr, int tag);
    enq_valid = 1; enq_bank = BW'(b); enq_row = ROW_W'(row); enq_wr = wr[0]; enq_tag = TAG_W'(tag);
    step();
    enq_valid = 0;
  endtask

  task automatic rm(int b, int tag);
    rm_valid = 1; rm_bank = BW'(b); rm_tag = TAG_W'(tag);
    step();
    rm_valid = 0;
  endtask

  task automatic set_open(int b, bit o, int row);
    bank_open[b] = o; open_row[b*ROW_W +: ROW_W] = ROW_W'(row);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog expired got 0 exp 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0; fifo_mode = 0; space_ok = 1; enq_valid = 0; enq_wr = 0; rm_valid = 0;
    enq_bank = '0; rm_bank = '0; hint_bank = '0; enq_row = '0; hint_row = '0;
    enq_tag = '0; rm_tag = '0; bank_open = '0; open_row = '0;
    for (int b = 0; b < NB; b++) m_cnt[b] = 0;
    repeat (3) @(negedge clk);
    ph = "R11";
    chk(gnt_valid == '0, "reset gnt_valid", int'(gnt_valid), 0);
    chk(more_req == '0, "reset more_req", int'(more_req), 0);
    rst_ni = 1;
    @(negedge clk);
    step();

    // Arrival order, closed bank
    ph = "R1";
    enq(0, 5, 0, 1); enq(0, 7, 1, 2); enq(0, 5, 0, 3); enq(0, 9, 1, 4);
    ph = "R3"; step();
    ph = "R4"; step();
    // Open-row selection
    ph = "R2";
    set_open(0, 1, 7); step(); step();
    set_open(0, 1, 9); step(); step();
    ph = "R3";
    set_open(0, 1, 3); step(); step();
    set_open(0, 0, 9); step(); step();
    // Hints
    ph = "R6"; step();
    ph = "R7";
    hint_bank = 0; hint_row = 5; step();
    hint_row = 7; step();
    // Full queue and admission gating
    ph = "R10";
    enq(0, 1, 0, 5); step();
    space_ok = 0; enq(1, 2, 0, 6); step(); space_ok = 1;
    // Removal from the middle and by absent tag
    ph = "R5";
    set_open(0, 1, 9);
    rm(0, 2); step();
    rm(0, 12); step();
    enq(0, 5, 1, 3); step();
    rm(0, 3); step(); step();
    // Same-cycle removal and append on full queue
    ph = "R9";
    enq(0, 8, 0, 7); step();
    enq_valid = 1; enq_bank = 0; enq_row = 8'd11; enq_wr = 1; enq_tag = 4'd8;
    rm_valid = 1; rm_bank = 0; rm_tag = 4'd4;
    step(); enq_valid = 0; rm_valid = 0; step();
    // Strict FIFO
    ph = "R8";
    fifo_mode = 1;
    set_open(0, 1, 8); step(); step();
    hint_bank = 0; hint_row = 5; step();
    hint_row = 8; step();
    rm(0, 8); step();
    rm(0, 15); step();
    fifo_mode = 0;
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < DEPTH; k++) begin rm_valid = 1; rm_bank = BW'(b); fifo_mode = 1; step(); end
    end
    rm_valid = 0; fifo_mode = 0; step();

    // Random traffic with small row and tag pools
    ph = "R1";
    for (int n = 0; n < 600; n++) begin
      enq_valid = ($urandom_range(0, 3) != 0);
      enq_bank  = BW'($urandom_range(0, NB - 1));
      enq_row   = ROW_W'($urandom_range(0, 3));
      enq_wr    = 1'($urandom_range(0, 1));
      enq_tag   = TAG_W'($urandom_range(0, 5));
      space_ok  = ($urandom_range(0, 7) != 0);
      rm_valid  = ($urandom_range(0, 2) == 0);
      rm_bank   = BW'($urandom_range(0, NB - 1));
      rm_tag    = TAG_W'($urandom_range(0, 5));
      fifo_mode = (n >= 450);
      bank_open = NB'($urandom_range(0, (1 << NB) - 1));
      for (int b = 0; b < NB; b++) open_row[b*ROW_W +: ROW_W] = ROW_W'($urandom_range(0, 3));
      hint_bank = BW'($urandom_range(0, NB - 1));
      hint_row  = ROW_W'($urandom_range(0, 3));
      if (n == 300) ph = "R9";
      if (n == 450) ph = "R8";
      step();
    end
    enq_valid = 0; rm_valid = 0;
    step();

    done = 1;
    summary();
    $finish;
  end
endmodule